// File: doc/BRIEF.md
# Performance-Monitor Event-Capability Read Gate

This block sits in front of a read-only, 64-bit register that advertises which common performance-monitor events a core implements. For every system-register read request it checks whether the instruction encoding selects this register. It then decides whether the read returns data, is reported as undefined, or traps to a higher exception level. When the read completes, the block returns the capability bit vector. The upper half of that vector is filled in only when the extended monitor feature level is present.

Requests enter on a valid/ready channel. Each one carries the encoding fields, a write flag, the current exception level, and a snapshot of the debug and trap-control state. A single-entry output register holds the decision until the consumer takes it. If the response channel stalls, the request channel stalls with it. A request is accepted in a cycle where `req_ready` is high, and `req_ready` is high whenever the output register is empty or is being drained in that same cycle. Every response stays stable for as long as it is offered and not taken.

Top module: `pmcap_read_gate`

## Requirements
- R1: A request hits only when op0=2'b11, op1=3'b011, CRn=4'b1001, CRm=4'b1100 and op2=3'b110. Any other encoding responds with `rsp_nohit`=1, result 3'b000, target 0, class 0 and data 0.
- R2: A hit with `feat_pmu`=0 gives result undefined. The result code is bit 2 = ok, bit 1 = undefined, bit 0 = trap.
- R3: A hit with `req_is_write`=1 gives result undefined.
- R4: A hit read at level 3 (`req_el`=2'd3) always gives result ok, whatever the trap and debug configuration.
- R5: At levels 0, 1 and 2 the highest-priority check is undefined. It fires when halted, EL3 present, secure-debug-disable, trap-priority option and the EL3 trap bit are all set.
- R6: At level 0 only, if the user-enable bit is clear, the read traps. The target is level 2 when EL2 is enabled and TGE is set, and level 1 otherwise.
- R7: At levels 0 and 1, if EL2 is enabled and the EL2 trap bit is set, the read traps to level 2. Level 2 never takes this check.
- R8: If EL3 is present and the EL3 trap bit is set, the read is undefined when halted with secure-debug-disable set. Otherwise it traps to level 3. If no earlier check fires, the result is ok.
- R9: Every trap reports class 6'h18 with target 1, 2 or 3. When the result is not a trap, target and class are 0.
- R10: Data bit n (0..31) reports common event n as `EVT_LO & ~RSVD_LO`. Data is all zero unless the result is ok.
- R11: Data bits [63:32] report events 0x4000+n as `EVT_HI & ~RSVD_HI` when `feat_pmu_v3p1`=1, and read zero otherwise.
- R12: A response appears one cycle after acceptance. While `rsp_valid`=1 and `rsp_ready`=0, `req_ready` is 0 and all response fields hold.
- R13: A valid response has either `rsp_nohit`=1 with result zero, or `rsp_nohit`=0 with exactly one result bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be accepted |
| req_op0 | input | 2 | Encoding field op0 |
| req_op1 | input | 3 | Encoding field op1 |
| req_crn | input | 4 | Encoding field CRn |
| req_crm | input | 4 | Encoding field CRm |
| req_op2 | input | 3 | Encoding field op2 |
| req_is_write | input | 1 | Request is a write |
| req_el | input | 2 | Current exception level |
| cfg_halted | input | 1 | Core in debug halt |
| cfg_el3_present | input | 1 | EL3 implemented |
| cfg_el2_enabled | input | 1 | EL2 enabled |
| cfg_sdd | input | 1 | Secure debug disabled |
| cfg_el3_trap_prio | input | 1 | EL3 trap takes priority when secure debug is disabled |
| cfg_el3_tpm | input | 1 | EL3 monitor-trap bit |
| cfg_el2_tpm | input | 1 | EL2 monitor-trap bit |
| cfg_user_en | input | 1 | Level-0 access enable |
| cfg_tge | input | 1 | Route level-0 traps to level 2 |
| feat_pmu | input | 1 | Base monitor feature present |
| feat_pmu_v3p1 | input | 1 | Extended monitor feature level present |
| rsp_valid | output | 1 | Response offered |
| rsp_ready | input | 1 | Response taken |
| rsp_nohit | output | 1 | Encoding does not select this register |
| rsp_result | output | 3 | One-hot {ok, undefined, trap} |
| rsp_target | output | 2 | Trap target level, 0 unless trapping |
| rsp_class | output | 6 | Syndrome class, 0 unless trapping |
| rsp_data | output | 64 | Read data, 0 unless ok |

## Verification
The assertions assume that every configuration and feature input is meaningful only together with the request it accompanies. They check a response against the inputs seen in the accepting cycle, so the request and its configuration must be stable in that cycle. The bench drives all fields on the falling edge, before it raises `req_valid`. It changes them only after the acceptance edge. The bench also keeps `req_el` within the four defined levels and drops `req_valid` once each request is taken.

// File: rtl/pmcap_pkg.sv
package pmcap_pkg;
  localparam int DATA_W  = 64;
  localparam int HALF_W  = DATA_W / 2;
  localparam int CLASS_W = 6;

  localparam logic [1:0] ENC_OP0 = 2'b11;
  localparam logic [2:0] ENC_OP1 = 3'b011;
  localparam logic [3:0] ENC_CRN = 4'b1001;
  localparam logic [3:0] ENC_CRM = 4'b1100;
  localparam logic [2:0] ENC_OP2 = 3'b110;

  localparam logic [CLASS_W-1:0] TRAP_CLASS = 6'h18;

  typedef enum logic [1:0] {LVL0 = 2'd0, LVL1 = 2'd1, LVL2 = 2'd2, LVL3 = 2'd3} lvl_e;

  localparam int RES_OK    = 2;
  localparam int RES_UNDEF = 1;
  localparam int RES_TRAP  = 0;

  typedef struct packed {
    logic               halted;
    logic               el3_present;
    logic               el2_enabled;
    logic               sdd;
    logic               el3_trap_prio;
    logic               el3_tpm;
    logic               el2_tpm;
    logic               user_en;
    logic               tge;
  } ctl_t;

  typedef struct packed {
    logic               nohit;
    logic [2:0]         result;
    logic [1:0]         target;
    logic [CLASS_W-1:0] ecls;
    logic [DATA_W-1:0]  data;
  } rsp_t;
endpackage

// File: rtl/pmcap_enc_match.sv
module pmcap_enc_match
  import pmcap_pkg::*;
(
  input  logic [1:0] op0,
  input  logic [2:0] op1,
  input  logic [3:0] crn,
  input  logic [3:0] crm,
  input  logic [2:0] op2,
  output logic       hit
);
  assign hit = (op0 == ENC_OP0) && (op1 == ENC_OP1) && (crn == ENC_CRN) &&
               (crm == ENC_CRM) && (op2 == ENC_OP2);
endmodule

// File: rtl/pmcap_trap_chain.sv
module pmcap_trap_chain
  import pmcap_pkg::*;
(
  input  logic       feat_pmu,
  input  logic       is_write,
  input  lvl_e       el,
  input  ctl_t       ctl,
  output logic [2:0] result,
  output logic [1:0] target
);
  logic early_undef;
  logic el3_trap_hit;
  logic sdd_halt;

  assign sdd_halt     = ctl.halted && ctl.sdd;
  assign el3_trap_hit = ctl.el3_present && ctl.el3_tpm;
  assign early_undef  = sdd_halt && ctl.el3_trap_prio && el3_trap_hit;

  always_comb begin
    result = '0;
    target = 2'd0;
    result[RES_OK] = 1'b1;
    if (!feat_pmu || is_write) begin
      result = '0;
      result[RES_UNDEF] = 1'b1;
    end else if (el != LVL3) begin
      if (early_undef) begin
        result = '0;
        result[RES_UNDEF] = 1'b1;
      end else if (el == LVL0 && !ctl.user_en) begin
        result = '0;
        result[RES_TRAP] = 1'b1;
        target = (ctl.el2_enabled && ctl.tge) ? 2'd2 : 2'd1;
      end else if (el != LVL2 && ctl.el2_enabled && ctl.el2_tpm) begin
        result = '0;
        result[RES_TRAP] = 1'b1;
        target = 2'd2;
      end else if (el3_trap_hit) begin
        result = '0;
        if (sdd_halt) begin
          result[RES_UNDEF] = 1'b1;
        end else begin
          result[RES_TRAP] = 1'b1;
          target = 2'd3;
        end
      end
    end
  end
endmodule

// File: rtl/pmcap_data_mask.sv
module pmcap_data_mask
  import pmcap_pkg::*;
#(
  parameter logic [HALF_W-1:0] EVT_LO  = '0,
  parameter logic [HALF_W-1:0] RSVD_LO = '0,
  parameter logic [HALF_W-1:0] EVT_HI  = '0,
  parameter logic [HALF_W-1:0] RSVD_HI = '0
) (
  input  logic              feat_v3p1,
  input  logic              enable,
  output logic [DATA_W-1:0] data
);
  localparam int NHALF = DATA_W / HALF_W;
  localparam logic [DATA_W-1:0] EVT_ALL  = {EVT_HI, EVT_LO};
  localparam logic [DATA_W-1:0] RSVD_ALL = {RSVD_HI, RSVD_LO};

  for (genvar h = 0; h < NHALF; h++) begin : g_half
    logic half_on;
    if (h == 0) begin : g_base
      assign half_on = enable;
    end else begin : g_ext
      assign half_on = enable && feat_v3p1;
    end
    assign data[h*HALF_W +: HALF_W] = half_on ?
      (EVT_ALL[h*HALF_W +: HALF_W] & ~RSVD_ALL[h*HALF_W +: HALF_W]) : '0;
  end
endmodule

// File: rtl/pmcap_read_gate.sv
module pmcap_read_gate
  import pmcap_pkg::*;
#(
  parameter logic [31:0] EVT_LO  = 32'hFFFF_00FF,
  parameter logic [31:0] RSVD_LO = 32'h0F00_0000,
  parameter logic [31:0] EVT_HI  = 32'h0000_0FFF,
  parameter logic [31:0] RSVD_HI = 32'h0000_0F00
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [1:0]  req_op0,
  input  logic [2:0]  req_op1,
  input  logic [3:0]  req_crn,
  input  logic [3:0]  req_crm,
  input  logic [2:0]  req_op2,
  input  logic        req_is_write,
  input  logic [1:0]  req_el,
  input  logic        cfg_halted,
  input  logic        cfg_el3_present,
  input  logic        cfg_el2_enabled,
  input  logic        cfg_sdd,
  input  logic        cfg_el3_trap_prio,
  input  logic        cfg_el3_tpm,
  input  logic        cfg_el2_tpm,
  input  logic        cfg_user_en,
  input  logic        cfg_tge,
  input  logic        feat_pmu,
  input  logic        feat_pmu_v3p1,
  output logic        rsp_valid,
  input  logic        rsp_ready,
  output logic        rsp_nohit,
  output logic [2:0]  rsp_result,
  output logic [1:0]  rsp_target,
  output logic [5:0]  rsp_class,
  output logic [63:0] rsp_data
);
  ctl_t              ctl;
  logic              hit;
  logic [2:0]        chain_res;
  logic [1:0]        chain_tgt;
  logic [DATA_W-1:0] cap_data;
  rsp_t              nxt;
  rsp_t              held;
  logic              accept;

  assign ctl = '{halted: cfg_halted, el3_present: cfg_el3_present,
                 el2_enabled: cfg_el2_enabled, sdd: cfg_sdd,
                 el3_trap_prio: cfg_el3_trap_prio, el3_tpm: cfg_el3_tpm,
                 el2_tpm: cfg_el2_tpm, user_en: cfg_user_en, tge: cfg_tge};

  pmcap_enc_match u_match (
    .op0(req_op0), .op1(req_op1), .crn(req_crn), .crm(req_crm), .op2(req_op2),
    .hit(hit)
  );

  pmcap_trap_chain u_chain (
    .feat_pmu(feat_pmu), .is_write(req_is_write), .el(lvl_e'(req_el)), .ctl(ctl),
    .result(chain_res), .target(chain_tgt)
  );

  pmcap_data_mask #(
    .EVT_LO(EVT_LO), .RSVD_LO(RSVD_LO), .EVT_HI(EVT_HI), .RSVD_HI(RSVD_HI)
  ) u_mask (
    .feat_v3p1(feat_pmu_v3p1),
    .enable(hit && chain_res[RES_OK]),
    .data(cap_data)
  );

  always_comb begin
    nxt        = '0;
    nxt.nohit  = !hit;
    if (hit) begin
      nxt.result = chain_res;
      nxt.target = chain_tgt;
      nxt.ecls   = chain_res[RES_TRAP] ? TRAP_CLASS : '0;
      nxt.data   = cap_data;
    end
  end

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      held      <= '0;
    end else if (accept) begin
      rsp_valid <= 1'b1;
      held      <= nxt;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  assign rsp_nohit  = held.nohit;
  assign rsp_result = held.result;
  assign rsp_target = held.target;
  assign rsp_class  = held.ecls;
  assign rsp_data   = held.data;
endmodule

// File: rtl/pmcap_read_gate_chk.sv
module pmcap_read_gate_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic [1:0]  req_op0,
  input logic [2:0]  req_op1,
  input logic [3:0]  req_crn,
  input logic [3:0]  req_crm,
  input logic [2:0]  req_op2,
  input logic        req_is_write,
  input logic [1:0]  req_el,
  input logic        feat_pmu,
  input logic        feat_pmu_v3p1,
  input logic        rsp_valid,
  input logic        rsp_ready,
  input logic        rsp_nohit,
  input logic [2:0]  rsp_result,
  input logic [1:0]  rsp_target,
  input logic [5:0]  rsp_class,
  input logic [63:0] rsp_data
);
  logic sel;
  assign sel = (req_op0 == 2'b11) && (req_op1 == 3'b011) && (req_crn == 4'b1001) &&
               (req_crm == 4'b1100) && (req_op2 == 3'b110);

  p_shape_r13: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_nohit ? (rsp_result == 3'b000) : ($countones(rsp_result) == 1)));

  p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_result) &&
                                   $stable(rsp_data) && $stable(rsp_target)));

  p_trap_class_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_result[0]) |-> (rsp_class == 6'h18 && rsp_target != 2'd0));

  p_data_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_result[2]) |-> (rsp_data == 64'd0));

  p_el3_ok_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && sel && !req_is_write && feat_pmu && req_el == 2'd3)
      |=> (rsp_result == 3'b100));

  p_hi_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !feat_pmu_v3p1) |=> (rsp_data[63:32] == 32'd0));

  p_nohit_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !sel) |=> (rsp_nohit && rsp_class == 6'd0));
endmodule

bind pmcap_read_gate pmcap_read_gate_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_op0(req_op0), .req_op1(req_op1), .req_crn(req_crn), .req_crm(req_crm),
  .req_op2(req_op2), .req_is_write(req_is_write), .req_el(req_el),
  .feat_pmu(feat_pmu), .feat_pmu_v3p1(feat_pmu_v3p1),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_nohit(rsp_nohit),
  .rsp_result(rsp_result), .rsp_target(rsp_target), .rsp_class(rsp_class),
  .rsp_data(rsp_data)
);

// File: tb/pmcap_read_gate_bench.sv
`timescale 1ns/1ps
module pmcap_read_gate_bench;
  localparam logic [31:0] B_EVT_LO  = 32'hFFFF_00FF;
  localparam logic [31:0] B_RSVD_LO = 32'h0F00_0000;
  localparam logic [31:0] B_EVT_HI  = 32'h0000_0FFF;
  localparam logic [31:0] B_RSVD_HI = 32'h0000_0F00;
  localparam logic [63:0] FULL = {B_EVT_HI & ~B_RSVD_HI, B_EVT_LO & ~B_RSVD_LO};
  localparam logic [63:0] LOW  = {32'd0, B_EVT_LO & ~B_RSVD_LO};
  localparam logic [2:0] OK = 3'b100, UD = 3'b010, TR = 3'b001;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready;
  logic [1:0] req_op0; logic [2:0] req_op1; logic [3:0] req_crn, req_crm; logic [2:0] req_op2;
  logic req_is_write; logic [1:0] req_el;
  logic cfg_halted, cfg_el3_present, cfg_el2_enabled, cfg_sdd, cfg_el3_trap_prio;
  logic cfg_el3_tpm, cfg_el2_tpm, cfg_user_en, cfg_tge, feat_pmu, feat_pmu_v3p1;
  logic rsp_valid, rsp_ready = 1'b1, rsp_nohit;
  logic [2:0] rsp_result; logic [1:0] rsp_target; logic [5:0] rsp_class; logic [63:0] rsp_data;
  int errors = 0, checks = 0, cycles = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pmcap_read_gate #(.EVT_LO(B_EVT_LO), .RSVD_LO(B_RSVD_LO), .EVT_HI(B_EVT_HI),
                    .RSVD_HI(B_RSVD_HI)) u_pmcap_read_gate (.*);

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000 && !done) begin
      done = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic clear_cfg();
    req_op0 = 2'b11; req_op1 = 3'b011; req_crn = 4'b1001; req_crm = 4'b1100; req_op2 = 3'b110;
    req_is_write = 1'b0; req_el = 2'd1;
    cfg_halted = 0; cfg_el3_present = 0; cfg_el2_enabled = 0; cfg_sdd = 0;
    cfg_el3_trap_prio = 0; cfg_el3_tpm = 0; cfg_el2_tpm = 0; cfg_user_en = 1; cfg_tge = 0;
    feat_pmu = 1; feat_pmu_v3p1 = 1;
  endtask

  // drive at negedge, accepted at next posedge, sample at following negedge
  task automatic send_and_check(string tag, logic nohit, logic [2:0] res,
                                logic [1:0] tgt, logic [63:0] data);
    req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk({tag, " valid"}, {63'd0, rsp_valid}, 64'd1);
    chk({tag, " nohit"}, {63'd0, rsp_nohit}, {63'd0, nohit});
    chk({tag, " result"}, {61'd0, rsp_result}, {61'd0, res});
    chk({tag, " target"}, {62'd0, rsp_target}, {62'd0, tgt});
    chk({tag, " class"}, {58'd0, rsp_class}, (res == TR) ? 64'h18 : 64'd0);
    chk({tag, " data"}, rsp_data, data);
    @(negedge clk);
    clear_cfg();
  endtask

  task automatic t_reset();
    chk("R12 reset rsp_valid", {63'd0, rsp_valid}, 64'd0);
    chk("R12 reset req_ready", {63'd0, req_ready}, 64'd1);
  endtask

  task automatic t_decode();
    req_crm = 4'b1101;          send_and_check("R1 crm miss", 1, 3'b000, 0, 0);
    req_op2 = 3'b111;           send_and_check("R1 op2 miss", 1, 3'b000, 0, 0);
    req_el = 2'd3;              send_and_check("R1 hit el3", 0, OK, 0, FULL);
  endtask

  task automatic t_feature_write();
    feat_pmu = 0; req_el = 2'd3; send_and_check("R2 no pmu", 0, UD, 0, 0);
    req_is_write = 1; req_el = 2'd3; send_and_check("R3 write", 0, UD, 0, 0);
  endtask

  task automatic t_el3();
    req_el = 2'd3; cfg_halted = 1; cfg_el3_present = 1; cfg_sdd = 1; cfg_el3_trap_prio = 1;
    cfg_el3_tpm = 1; cfg_el2_enabled = 1; cfg_el2_tpm = 1; cfg_user_en = 0;
    send_and_check("R4 el3 all set", 0, OK, 0, FULL);
    req_el = 2'd3; feat_pmu_v3p1 = 0; send_and_check("R11 no v3p1", 0, OK, 0, LOW);
    req_el = 2'd0; send_and_check("R10 el0 ok data", 0, OK, 0, FULL);
  endtask

  task automatic t_early_undef();
    req_el = 2'd1; cfg_halted = 1; cfg_el3_present = 1; cfg_sdd = 1; cfg_el3_trap_prio = 1;
    cfg_el3_tpm = 1; cfg_el2_enabled = 1; cfg_el2_tpm = 1;
    send_and_check("R5 el1 over el2 trap", 0, UD, 0, 0);
    req_el = 2'd0; cfg_halted = 1; cfg_el3_present = 1; cfg_sdd = 1; cfg_el3_trap_prio = 1;
    cfg_el3_tpm = 1; cfg_user_en = 0;
    send_and_check("R5 el0 over user", 0, UD, 0, 0);
  endtask

  task automatic t_user();
    req_el = 2'd0; cfg_user_en = 0; cfg_el2_enabled = 1; cfg_tge = 1;
    send_and_check("R6 tge to el2", 0, TR, 2, 0);
    req_el = 2'd0; cfg_user_en = 0; cfg_tge = 1;
    send_and_check("R6 tge no el2", 0, TR, 1, 0);
    req_el = 2'd0; cfg_user_en = 0; cfg_el2_enabled = 1; cfg_el2_tpm = 1;
    send_and_check("R6 over el2 tpm", 0, TR, 1, 0);
  endtask

  task automatic t_el2_trap();
    req_el = 2'd1; cfg_el2_enabled = 1; cfg_el2_tpm = 1;
    send_and_check("R7 el1", 0, TR, 2, 0);
    req_el = 2'd0; cfg_el2_enabled = 1; cfg_el2_tpm = 1;
    send_and_check("R7 el0", 0, TR, 2, 0);
    req_el = 2'd2; cfg_el2_enabled = 1; cfg_el2_tpm = 1;
    send_and_check("R7 el2 skips", 0, OK, 0, FULL);
    req_el = 2'd1; cfg_el2_tpm = 1;
    send_and_check("R7 el2 disabled", 0, OK, 0, FULL);
  endtask

  task automatic t_el3_trap();
    req_el = 2'd2; cfg_el3_present = 1; cfg_el3_tpm = 1;
    send_and_check("R8 trap el3", 0, TR, 3, 0);
    req_el = 2'd1; cfg_el3_present = 1; cfg_el3_tpm = 1; cfg_halted = 1; cfg_sdd = 1;
    send_and_check("R8 halted sdd undef", 0, UD, 0, 0);
    req_el = 2'd2; cfg_el3_tpm = 1;
    send_and_check("R8 no el3", 0, OK, 0, FULL);
  endtask

  task automatic t_backpressure();
    rsp_ready = 0; req_el = 2'd2; cfg_el3_present = 1; cfg_el3_tpm = 1;
    req_valid = 1;
    @(posedge clk); @(negedge clk);
    clear_cfg(); req_el = 2'd3;     // second request waits
    chk("R12 stall ready low", {63'd0, req_ready}, 64'd0);
    @(posedge clk); @(negedge clk);
    chk("R12 held result", {61'd0, rsp_result}, {61'd0, TR});
    chk("R12 held target", {62'd0, rsp_target}, 64'd3);
    rsp_ready = 1;
    @(posedge clk); @(negedge clk);
    req_valid = 0;
    chk("R12 next result", {61'd0, rsp_result}, {61'd0, OK});
    chk("R12 next data", rsp_data, FULL);
    @(posedge clk); @(negedge clk);
    chk("R12 drained", {63'd0, rsp_valid}, 64'd0);
    clear_cfg();
  endtask

  initial begin
    clear_cfg();
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_decode();
    t_feature_write();
    t_el3();
    t_early_undef();
    t_user();
    t_el2_trap();
    t_el3_trap();
    t_backpressure();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule